// File: doc/BRIEF.md
# Selectable Test Pattern Injector

This block sits between a 14-bit converter core and the framing logic of a serial output link. A 4-bit mode input decides what reaches the back end. Code zero forwards the live converter samples. Any other code cuts off the live samples and sends a generated pattern instead. The patterns are fixed levels, two alternating words and two pseudorandom sequences of different lengths. Each sample leaves the block as a 16-bit word: the 14 data bits in the upper positions and two tail bits below them. Every output goes through one register.

Some sources pass through a number-format stage and others skip it. When the format input is high, that stage changes offset binary into two's complement by inverting the most significant data bit. Live samples, the fixed levels and both pseudorandom words use this stage. The alternating words and unused codes skip it.

Each pseudorandom generator has its own hold input. While the hold is high, the generator stays at its seed and outputs its first word on every sample. When the hold drops, the sequence starts again from the beginning. This gives a fixed known word on the link, which helps when bringing up a board.

Top module: `tpat_injector`

## Requirements
- R1: An active-low reset, asynchronous, clears `sample_out` to zero at once. It also returns both generators to their seed and the alternation phase to its first word.
- R2: With mode 0, `sample_out[15:2]` shows the `live_sample` value from the previous clock edge, one cycle later. When the format input was high, bit 13 of that value is inverted.
- R3: With any nonzero mode, the output does not depend on `live_sample` at all.
- R4: Modes 1, 2 and 3 give the offset-binary values 0x2000, 0x3FFF and 0x0000 in turn. Bit 13 is inverted when the format input is high.
- R5: Mode 4 gives data words that alternate 0x2AAA, 0x1555 on successive clocks, without formatting. The phase runs freely from reset: the first clock after reset gives 0x2AAA.
- R6: Mode 7 gives data words that alternate 0x0000, 0x3FFF, without formatting, on the same free-running phase as R5. The phase-0 word is 0x0000.
- R7: Mode 6 gives the short sequence and is formatted like R4. The bit stream follows b[n] = b[n-9] XOR b[n-5] from an all-ones history. Each clock takes the next 14 bits, and the earliest bit goes to data bit 13. The generator advances every clock whichever mode is selected.
- R8: Mode 5 gives the long sequence in the same way as R7. Its bit stream follows b[n] = b[n-23] XOR b[n-18] from an all-ones history.
- R9: `hold_short` and `hold_long` each act only on their own generator. While a hold is high, that generator outputs its first word after seed on every clock. The clock after the hold drops shows that first word again, and the sequence then goes on from there.
- R10: Modes 8 to 15 give an all-zero output, whatever the format input is.
- R11: A change of mode, format or hold shows on `sample_out` just after the next rising clock edge. It does not change earlier or later.
- R12: `sample_out[1:0]`, the two tail bits, are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; everything advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_sample | input | 14 | Offset-binary sample from the converter core |
| mode | input | 4 | Source select: 0 live, 1 to 7 patterns, 8 to 15 zero |
| twos_fmt | input | 1 | Changes formatted sources to two's complement |
| hold_long | input | 1 | Keeps the long generator at its seed |
| hold_short | input | 1 | Keeps the short generator at its seed |
| sample_out | output | 16 | Data in bits 15:2, tail bits in 1:0 |

## Verification
Two things can meet in one cycle: a hold release on a generator, and a mode change that selects that same generator. The stimulus switches from the short sequence to the long one on the exact edge where `hold_long` drops. On that edge the expected word is the long seed word. The expected words after it follow the long sequence from its start. The bench tracks the history-based bit recurrence for both generators on every clock, and compares each output against it. It also checks that holding one generator never moves the other, and that the format input flipping during a hold changes only bit 13.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

  localparam int MODE_BITS = 4;

  typedef enum logic [MODE_BITS-1:0] {
    MODE_LIVE     = 4'd0,
    MODE_MID      = 4'd1,
    MODE_POS_FS   = 4'd2,
    MODE_NEG_FS   = 4'd3,
    MODE_CHECKER  = 4'd4,
    MODE_PN_LONG  = 4'd5,
    MODE_PN_SHORT = 4'd6,
    MODE_TOGGLE   = 4'd7
  } tmode_e;

endpackage

// File: rtl/tpat_prbs.sv
module tpat_prbs #(
  parameter int STATE_W = 9,
  parameter int TAP     = 5,
  parameter int WORD_W  = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  output logic [WORD_W-1:0]  word,
  output logic [STATE_W-1:0] state
);

  localparam logic [STATE_W-1:0] SEED = '1;

  // Advance the recurrence WORD_W steps; the earliest new bit ends up in the word MSB.
  function automatic logic [STATE_W+WORD_W-1:0] run_chunk(input logic [STATE_W-1:0] s_in);
    logic [STATE_W-1:0] s;
    logic [WORD_W-1:0]  w;
    logic               nb;
    s = s_in;
    w = '0;
    for (int i = 0; i < WORD_W; i++) begin
      nb = s[STATE_W-1] ^ s[TAP-1];
      w  = {w[WORD_W-2:0], nb};
      s  = {s[STATE_W-2:0], nb};
    end
    return {s, w};
  endfunction

  logic [STATE_W-1:0] src_state;
  logic [STATE_W-1:0] nxt_state;

  assign src_state = hold ? SEED : state;
  assign {nxt_state, word} = run_chunk(src_state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEED;
    end else begin
      state <= hold ? SEED : nxt_state;
    end
  end

endmodule

// File: rtl/tpat_select.sv
module tpat_select
  import tpat_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic [MODE_BITS-1:0] mode,
  input  logic [DATA_W-1:0]    live_sample,
  input  logic [DATA_W-1:0]    short_word,
  input  logic [DATA_W-1:0]    long_word,
  input  logic                 alt_phase,
  output logic [DATA_W-1:0]    raw_word,
  output logic                 use_fmt
);

  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic [DATA_W-1:0] checker_word(input logic ph);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W; i++) begin
      w[i] = (i % 2 == 1) ^ ph;
    end
    return w;
  endfunction

  always_comb begin
    raw_word = '0;
    use_fmt  = 1'b0;
    case (mode)
      MODE_LIVE:     begin raw_word = live_sample; use_fmt = 1'b1; end
      MODE_MID:      begin raw_word = MID_CODE;    use_fmt = 1'b1; end
      MODE_POS_FS:   begin raw_word = '1;          use_fmt = 1'b1; end
      MODE_NEG_FS:   begin raw_word = '0;          use_fmt = 1'b1; end
      MODE_CHECKER:  raw_word = checker_word(alt_phase);
      MODE_PN_LONG:  begin raw_word = long_word;   use_fmt = 1'b1; end
      MODE_PN_SHORT: begin raw_word = short_word;  use_fmt = 1'b1; end
      MODE_TOGGLE:   raw_word = {DATA_W{alt_phase}};
      default:       raw_word = '0;
    endcase
  end

endmodule

// File: rtl/tpat_format.sv
module tpat_format #(
  parameter int DATA_W = 14
) (
  input  logic [DATA_W-1:0] raw_word,
  input  logic              use_fmt,
  input  logic              twos_fmt,
  output logic [DATA_W-1:0] fmt_word
);

  function automatic logic [DATA_W-1:0] offset_to_twos(input logic [DATA_W-1:0] v);
    return {~v[DATA_W-1], v[DATA_W-2:0]};
  endfunction

  assign fmt_word = (use_fmt && twos_fmt) ? offset_to_twos(raw_word) : raw_word;

endmodule

// File: rtl/tpat_injector.sv
module tpat_injector
  import tpat_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int TAIL_W    = 2,
  parameter int SHORT_LEN = 9,
  parameter int SHORT_TAP = 5,
  parameter int LONG_LEN  = 23,
  parameter int LONG_TAP  = 18
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DATA_W-1:0]           live_sample,
  input  logic [MODE_BITS-1:0]        mode,
  input  logic                        twos_fmt,
  input  logic                        hold_long,
  input  logic                        hold_short,
  output logic [DATA_W+TAIL_W-1:0]    sample_out
);

  localparam int OUT_W = DATA_W + TAIL_W;

  logic [DATA_W-1:0]    short_word;
  logic [DATA_W-1:0]    long_word;
  logic [DATA_W-1:0]    raw_word;
  logic [DATA_W-1:0]    fmt_word;
  logic [SHORT_LEN-1:0] short_state;
  logic [LONG_LEN-1:0]  long_state;
  logic                 use_fmt;
  logic                 alt_phase;

  tpat_prbs #(.STATE_W(SHORT_LEN), .TAP(SHORT_TAP), .WORD_W(DATA_W)) u_short (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (hold_short),
    .word  (short_word),
    .state (short_state)
  );

  tpat_prbs #(.STATE_W(LONG_LEN), .TAP(LONG_TAP), .WORD_W(DATA_W)) u_long (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (hold_long),
    .word  (long_word),
    .state (long_state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_phase <= 1'b0;
    end else begin
      alt_phase <= ~alt_phase;
    end
  end

  tpat_select #(.DATA_W(DATA_W)) u_sel (
    .mode        (mode),
    .live_sample (live_sample),
    .short_word  (short_word),
    .long_word   (long_word),
    .alt_phase   (alt_phase),
    .raw_word    (raw_word),
    .use_fmt     (use_fmt)
  );

  tpat_format #(.DATA_W(DATA_W)) u_fmt (
    .raw_word (raw_word),
    .use_fmt  (use_fmt),
    .twos_fmt (twos_fmt),
    .fmt_word (fmt_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_out <= '0;
    end else begin
      sample_out <= {fmt_word, {TAIL_W{1'b0}}};
    end
  end

endmodule

// File: rtl/tpat_injector_chk.sv
module tpat_injector_chk
  import tpat_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int TAIL_W    = 2,
  parameter int SHORT_LEN = 9,
  parameter int LONG_LEN  = 23
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [DATA_W-1:0]        live_sample,
  input logic [MODE_BITS-1:0]     mode,
  input logic                     twos_fmt,
  input logic                     hold_long,
  input logic                     hold_short,
  input logic [DATA_W+TAIL_W-1:0] sample_out,
  input logic [SHORT_LEN-1:0]     short_state,
  input logic [LONG_LEN-1:0]      long_state
);

  localparam int OUT_W = DATA_W + TAIL_W;
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic [1:0] since_rst;
  logic       settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  assign settled = (since_rst == 2'd3);

  // R2: live samples pass with one cycle of latency, formatted
  assert_live_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LIVE) |=>
      (sample_out[OUT_W-1:TAIL_W] == ($past(live_sample) ^ ($past(twos_fmt) ? MSB_MASK : '0))));

  // R10: unused codes give all zero
  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode[MODE_BITS-1] |=> (sample_out == '0));

  // R9: a held short generator keeps the output fixed
  assert_hold_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && hold_short && $past(hold_short) && (mode == MODE_PN_SHORT) &&
     ($past(mode) == MODE_PN_SHORT) && $stable(twos_fmt)) |=> $stable(sample_out));

  // R9: a held long generator keeps the output fixed
  assert_hold_long_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && hold_long && $past(hold_long) && (mode == MODE_PN_LONG) &&
     ($past(mode) == MODE_PN_LONG) && $stable(twos_fmt)) |=> $stable(sample_out));

  // R5: the checkerboard changes on every clock
  assert_checker_alt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && (mode == MODE_CHECKER) && ($past(mode) == MODE_CHECKER)) |=>
      (sample_out != $past(sample_out)));

  // R7: the short generator never locks up at zero
  assert_short_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    short_state != '0);

  // R8: the long generator never locks up at zero
  assert_long_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    long_state != '0);

endmodule

bind tpat_injector tpat_injector_chk #(
  .DATA_W(DATA_W), .TAIL_W(TAIL_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .live_sample (live_sample),
  .mode        (mode),
  .twos_fmt    (twos_fmt),
  .hold_long   (hold_long),
  .hold_short  (hold_short),
  .sample_out  (sample_out),
  .short_state (short_state),
  .long_state  (long_state)
);

// File: tb/tpat_injector_tb.sv
`timescale 1ns/1ps
module tpat_injector_tb;

  logic        clk;
  logic        rst_n;
  logic [13:0] live_i;
  logic [3:0]  mode_i;
  logic        twos_i;
  logic        hl_i;
  logic        hs_i;
  logic [15:0] sample_out;

  int checks;
  int fails;
  bit done;

  logic [8:0]  m9;
  logic [22:0] m23;
  logic        ph;

  tpat_injector u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .live_sample (live_i),
    .mode        (mode_i),
    .twos_fmt    (twos_i),
    .hold_long   (hl_i),
    .hold_short  (hs_i),
    .sample_out  (sample_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // History h[0] is the newest bit; h[k] is the bit k+1 steps old.
  function automatic void pn_run(input int len, input int tap, inout logic [22:0] h,
                                 output logic [13:0] w);
    logic nb;
    w = '0;
    for (int k = 0; k < 14; k++) begin
      nb = h[len-1] ^ h[tap-1];
      w  = {w[12:0], nb};
      h  = {h[21:0], nb};
    end
  endfunction

  function automatic logic [15:0] expect_out(input logic [3:0] m, input logic [13:0] lv,
                                             input logic t, input logic p,
                                             input logic [13:0] w9, input logic [13:0] w23);
    logic [13:0] v;
    logic        f;
    f = 1'b1;
    case (m)
      4'd0: v = lv;
      4'd1: v = 14'h2000;
      4'd2: v = 14'h3FFF;
      4'd3: v = 14'h0000;
      4'd4: begin v = p ? 14'h1555 : 14'h2AAA; f = 1'b0; end
      4'd5: v = w23;
      4'd6: v = w9;
      4'd7: begin v = p ? 14'h3FFF : 14'h0000; f = 1'b0; end
      default: begin v = 14'h0000; f = 1'b0; end
    endcase
    if (f && t) v = v ^ 14'h2000;
    return {v, 2'b00};
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    m9  = 9'h1FF;
    m23 = 23'h7FFFFF;
    ph  = 1'b0;
  endtask

  task automatic tick(input string req);
    logic [22:0] h;
    logic [13:0] w9;
    logic [13:0] w23;
    logic [15:0] e;
    h = hs_i ? 23'h0001FF : {14'b0, m9};
    pn_run(9, 5, h, w9);
    m9 = hs_i ? 9'h1FF : h[8:0];
    h = hl_i ? 23'h7FFFFF : m23;
    pn_run(23, 18, h, w23);
    m23 = hl_i ? 23'h7FFFFF : h;
    e = expect_out(mode_i, live_i, twos_i, ph, w9, w23);
    ph = ~ph;
    @(posedge clk);
    #1;
    check(req, sample_out, e);
  endtask

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0: return "R2";
      4'd1, 4'd2, 4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R8";
      4'd6: return "R7";
      4'd7: return "R6";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] seq [10];
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    live_i = '0;
    mode_i = '0;
    twos_i = 1'b0;
    hl_i   = 1'b0;
    hs_i   = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1", sample_out, 16'h0000);
    rst_n = 1'b1;

    // R2 and R12: live sweep with both formats
    for (int i = 0; i < 512; i++) begin
      live_i = 14'((i * 2731 + 5) & 14'h3FFF);
      twos_i = i[0];
      tick("R2");
    end
    live_i = 14'h3FFF;
    twos_i = 1'b0;
    tick("R12");
    check("R12", {14'h0, sample_out[1:0]}, 16'h0000);

    // Every mode code under both formats
    for (int m = 0; m < 16; m++) begin
      for (int t = 0; t < 2; t++) begin
        mode_i = 4'(m);
        twos_i = t[0];
        for (int k = 0; k < 6; k++) begin
          live_i = 14'((m * 1013 + k * 77 + t * 4099) & 14'h3FFF);
          tick(req_of(4'(m)));
        end
      end
    end

    // R3: live input swings wildly in pattern modes
    for (int m = 1; m < 8; m++) begin
      mode_i = 4'(m);
      for (int k = 0; k < 4; k++) begin
        live_i = k[0] ? 14'h3FFF : 14'h0000;
        twos_i = k[1];
        tick("R3");
      end
    end

    // R11: mode changes every clock
    seq = '{4'd0, 4'd1, 4'd6, 4'd4, 4'd2, 4'd7, 4'd5, 4'd3, 4'd0, 4'd9};
    for (int r = 0; r < 3; r++) begin
      foreach (seq[j]) begin
        mode_i = seq[j];
        live_i = 14'((j * 1500 + r * 333) & 14'h3FFF);
        twos_i = r[0];
        tick("R11");
      end
    end

    // R9: short hold, then release
    mode_i = 4'd6;
    twos_i = 1'b0;
    hs_i   = 1'b1;
    repeat (5) tick("R9");
    twos_i = 1'b1;
    repeat (2) tick("R9");
    hs_i = 1'b0;
    repeat (6) tick("R9");
    // long hold must not touch the short sequence
    hl_i = 1'b1;
    repeat (4) tick("R9");
    mode_i = 4'd5;
    repeat (4) tick("R9");
    // mode switch and hold release on the same edge
    mode_i = 4'd6;
    tick("R9");
    mode_i = 4'd5;
    hl_i   = 1'b0;
    repeat (6) tick("R9");
    // both held, alternating selection
    hs_i = 1'b1;
    hl_i = 1'b1;
    for (int k = 0; k < 8; k++) begin
      mode_i = k[0] ? 4'd5 : 4'd6;
      tick("R9");
    end
    hs_i = 1'b0;
    hl_i = 1'b0;
    repeat (4) tick("R8");

    // R1: reset in mid run restarts everything
    mode_i = 4'd6;
    repeat (3) tick("R7");
    rst_n = 1'b0;
    #1;
    check("R1", sample_out, 16'h0000);
    model_reset();
    #1;
    rst_n = 1'b1;
    repeat (3) tick("R1");
    mode_i = 4'd4;
    repeat (3) tick("R5");
    mode_i = 4'd5;
    repeat (3) tick("R8");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule